// File: doc/BRIEF.md
# Serial Audio Receiver with Attenuation

This block takes stereo 16-bit audio from a three-wire serial link (bit clock, word-select clock and data) and turns it into parallel left and right samples. A 6-bit attenuation code scales both samples before they leave the block. A flag reports a long run of silent input.

All logic runs on a master clock of 384 times the base sample rate. The three serial wires are sampled as ordinary inputs through two-flop synchronisers. Data is taken on each accepted rising edge of the bit clock. A level change on word select starts a new word, and the word-select level gives the channel. In normal rate the bit clock spans 12 master cycles. In double rate it spans 6. The rate input sets how close together two bit-clock rises may be before the later one is treated as a glitch.

The scaled left and right samples are updated together, and a single-cycle strobe marks each new pair. The silence flag is meant to drive a downstream mute.

Top module: `stereo_serial_rx`

## Requirements
- R1: After a change in the word-select level, the first 16 accepted bit-clock rises each capture one data bit, most significant bit first, and together they form one word.
- R2: A word captured while word select is high is the left sample; a word captured while it is low is the right sample.
- R3: Both outputs update together, once per completed right word, and the valid strobe is high for exactly one cycle each time.
- R4: Attenuation code 0 passes both samples through unchanged.
- R5: For codes 1 to 62 each output equals floor(sample × (63 − code) / 64), with the sample taken as two's complement.
- R6: Attenuation code 63 forces both outputs to zero.
- R7: Bit-clock rises after the 16th bit of a word, and before the next word-select change, have no effect on the captured word.
- R8: The zero flag rises once the configured number of consecutive stereo pairs (1024 by default) has been received with both words all zero. It stays high while zero pairs continue.
- R9: Any completed word with a nonzero value clears the zero flag and restarts the zero-pair count.
- R10: A bit-clock rise that comes less than 6 master cycles (normal rate) or 3 master cycles (double rate) after the last accepted rise is ignored.
- R11: Synchronous reset clears both sample outputs, the valid strobe and the zero flag, and sets the held attenuation to code 0.
- R12: Words are decoded correctly with a bit clock of 12 master cycles per bit in normal rate and 6 master cycles per bit in double rate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock, 384 times the base sample rate |
| rst | input | 1 | Synchronous reset, active high |
| rate_dbl | input | 1 | 0 = normal rate, 1 = double rate |
| atten_code | input | 6 | Attenuation code: 0 = unity, 63 = mute |
| bclk_in | input | 1 | Serial bit clock |
| wsel_in | input | 1 | Word select: high = left, low = right |
| sdata_in | input | 1 | Serial data, MSB first |
| left_out | output | 16 | Scaled left sample |
| right_out | output | 16 | Scaled right sample |
| pair_valid | output | 1 | One-cycle strobe when a new pair is presented |
| zero_flag | output | 1 | High after a long run of all-zero pairs |

## Verification
On every cycle the assertions check the following. The strobes are single-cycle. Codes 0 and 63 give a pass-through or zero result. The zero flag only rises right after an all-zero right word and drops after any nonzero word. A rejected glitch leaves the bit count untouched. Only the bench scenarios can show the full bit ordering and channel assignment, the floor rounding at intermediate codes, decoding at both bit-clock rates, and the exact pair count at which the zero flag rises.

// File: rtl/ssr_pkg.sv
package ssr_pkg;
  typedef enum logic {
    CH_RIGHT = 1'b0,
    CH_LEFT  = 1'b1
  } chan_e;
endpackage

// File: rtl/ssr_sync.sv
module ssr_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '0;
    else     stg[0] <= async_in;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stg
    always_ff @(posedge clk) begin
      if (rst) stg[s] <= '0;
      else     stg[s] <= stg[s-1];
    end
  end

  assign sync_out = stg[STAGES-1];
endmodule

// File: rtl/ssr_deser.sv
module ssr_deser
  import ssr_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int GAP_NORM = 6,
  parameter int GAP_DBL  = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                rate_dbl,
  input  logic                bclk_s,
  input  logic                ws_s,
  input  logic                dat_s,
  output logic                word_done,
  output chan_e               word_chan,
  output logic [SAMPLE_W-1:0] word_data
);
  localparam int CNT_W = $clog2(SAMPLE_W + 1);
  localparam int GAP_W = $clog2(GAP_NORM + 1) + 1;
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(SAMPLE_W);
  localparam logic [GAP_W-1:0] GAP_MAX  = '1;

  logic                bclk_d;
  logic [GAP_W-1:0]    gap_q;
  logic                ws_prev;
  logic [CNT_W-1:0]    cnt_q, cnt_nx;
  logic [SAMPLE_W-1:0] shift_q, shift_nx;
  logic                rise, accept, change;
  logic [GAP_W-1:0]    gap_min;

  assign rise    = bclk_s & ~bclk_d;
  assign gap_min = rate_dbl ? GAP_W'(GAP_DBL) : GAP_W'(GAP_NORM);
  assign accept  = rise && (gap_q >= gap_min);
  assign change  = (ws_s != ws_prev);

  always_comb begin
    shift_nx = shift_q;
    cnt_nx   = cnt_q;
    if (change) begin
      shift_nx = {{(SAMPLE_W-1){1'b0}}, dat_s};
      cnt_nx   = CNT_W'(1);
    end else if (cnt_q != CNT_FULL) begin
      shift_nx = {shift_q[SAMPLE_W-2:0], dat_s};
      cnt_nx   = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bclk_d    <= 1'b0;
      gap_q     <= GAP_MAX;
      ws_prev   <= 1'b0;
      cnt_q     <= CNT_FULL;
      shift_q   <= '0;
      word_done <= 1'b0;
      word_chan <= CH_RIGHT;
      word_data <= '0;
    end else begin
      bclk_d    <= bclk_s;
      word_done <= 1'b0;
      if (accept) begin
        gap_q   <= GAP_W'(1);
        ws_prev <= ws_s;
        cnt_q   <= cnt_nx;
        shift_q <= shift_nx;
        if (cnt_nx == CNT_FULL && (change || cnt_q != CNT_FULL)) begin
          word_done <= 1'b1;
          word_chan <= chan_e'(ws_s);
          word_data <= shift_nx;
        end
      end else if (gap_q != GAP_MAX) begin
        gap_q <= gap_q + GAP_W'(1);
      end
    end
  end

  // R1
  word_done_single_chk: assert property (@(posedge clk) disable iff (rst)
    word_done |=> !word_done);

  // R10
  glitch_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (rise && gap_q < gap_min) |=> $stable(cnt_q) && $stable(shift_q));
endmodule

// File: rtl/ssr_gain.sv
module ssr_gain #(
  parameter int SAMPLE_W = 16,
  parameter int CODE_W   = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [CODE_W-1:0]   code,
  input  logic                pair_go,
  input  logic [SAMPLE_W-1:0] left_in,
  input  logic [SAMPLE_W-1:0] right_in,
  output logic [SAMPLE_W-1:0] left_o,
  output logic [SAMPLE_W-1:0] right_o,
  output logic                valid_o
);
  localparam logic [CODE_W-1:0] CODE_MUTE = '1;
  localparam int PROD_W = SAMPLE_W + CODE_W + 1;

  logic [CODE_W-1:0]   code_q;
  logic [SAMPLE_W-1:0] ch_in  [2];
  logic [SAMPLE_W-1:0] ch_out [2];

  function automatic logic [SAMPLE_W-1:0] scale(
    input logic [SAMPLE_W-1:0] s,
    input logic [CODE_W-1:0]   c
  );
    logic [CODE_W-1:0]        factor;
    logic signed [PROD_W-1:0] prod;
    logic signed [PROD_W-1:0] shifted;
    factor  = CODE_MUTE - c;
    prod    = $signed(s) * $signed({1'b0, factor});
    shifted = prod >>> CODE_W;
    if (c == '0)             return s;
    else if (c == CODE_MUTE) return '0;
    else                     return shifted[SAMPLE_W-1:0];
  endfunction

  assign ch_in[0] = right_in;
  assign ch_in[1] = left_in;

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q  <= '0;
      valid_o <= 1'b0;
    end else begin
      code_q  <= code;
      valid_o <= pair_go;
    end
  end

  for (genvar c = 0; c < 2; c++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst)          ch_out[c] <= '0;
      else if (pair_go) ch_out[c] <= scale(ch_in[c], code_q);
    end
  end

  assign right_o = ch_out[0];
  assign left_o  = ch_out[1];

  // R3
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o);

  // R4
  unity_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (pair_go && code_q == '0) |=> (left_o == $past(left_in) && right_o == $past(right_in)));

  // R6
  mute_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (pair_go && code_q == CODE_MUTE) |=> (left_o == '0 && right_o == '0));
endmodule

// File: rtl/ssr_zero.sv
module ssr_zero
  import ssr_pkg::*;
#(
  parameter int SAMPLE_W   = 16,
  parameter int ZERO_PAIRS = 1024
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                word_done,
  input  chan_e               word_chan,
  input  logic [SAMPLE_W-1:0] word_data,
  output logic                zero_flag
);
  localparam int ZC_W = $clog2(ZERO_PAIRS + 1);
  localparam logic [ZC_W-1:0] ZC_LIM = ZC_W'(ZERO_PAIRS);

  logic [ZC_W-1:0] zc_q;
  logic            left_zero_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      zc_q        <= '0;
      left_zero_q <= 1'b0;
      zero_flag   <= 1'b0;
    end else if (word_done) begin
      if (word_data != '0) begin
        zc_q        <= '0;
        left_zero_q <= 1'b0;
        zero_flag   <= 1'b0;
      end else if (word_chan == CH_LEFT) begin
        left_zero_q <= 1'b1;
      end else if (left_zero_q) begin
        if (zc_q != ZC_LIM) zc_q <= zc_q + ZC_W'(1);
        if (zc_q + ZC_W'(1) >= ZC_LIM) zero_flag <= 1'b1;
      end
    end
  end

  // R8
  zero_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(zero_flag) |-> $past(word_done && word_chan == CH_RIGHT && word_data == '0));

  // R9
  zero_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (word_done && word_data != '0) |=> !zero_flag);
endmodule

// File: rtl/stereo_serial_rx.sv
module stereo_serial_rx
  import ssr_pkg::*;
#(
  parameter int SAMPLE_W    = 16,
  parameter int CODE_W      = 6,
  parameter int SYNC_STAGES = 2,
  parameter int GAP_NORM    = 6,
  parameter int GAP_DBL     = 3,
  parameter int ZERO_PAIRS  = 1024
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                rate_dbl,
  input  logic [CODE_W-1:0]   atten_code,
  input  logic                bclk_in,
  input  logic                wsel_in,
  input  logic                sdata_in,
  output logic [SAMPLE_W-1:0] left_out,
  output logic [SAMPLE_W-1:0] right_out,
  output logic                pair_valid,
  output logic                zero_flag
);
  localparam int SER_W = 3;

  logic [SER_W-1:0]    ser_s;
  logic                word_done;
  chan_e               word_chan;
  logic [SAMPLE_W-1:0] word_data;
  logic [SAMPLE_W-1:0] left_hold;
  logic                pair_go;

  ssr_sync #(.WIDTH(SER_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in ({bclk_in, wsel_in, sdata_in}),
    .sync_out (ser_s)
  );

  ssr_deser #(.SAMPLE_W(SAMPLE_W), .GAP_NORM(GAP_NORM), .GAP_DBL(GAP_DBL)) u_deser (
    .clk       (clk),
    .rst       (rst),
    .rate_dbl  (rate_dbl),
    .bclk_s    (ser_s[2]),
    .ws_s      (ser_s[1]),
    .dat_s     (ser_s[0]),
    .word_done (word_done),
    .word_chan (word_chan),
    .word_data (word_data)
  );

  always_ff @(posedge clk) begin
    if (rst)                                    left_hold <= '0;
    else if (word_done && word_chan == CH_LEFT) left_hold <= word_data;
  end

  assign pair_go = word_done && (word_chan == CH_RIGHT);

  ssr_gain #(.SAMPLE_W(SAMPLE_W), .CODE_W(CODE_W)) u_gain (
    .clk      (clk),
    .rst      (rst),
    .code     (atten_code),
    .pair_go  (pair_go),
    .left_in  (left_hold),
    .right_in (word_data),
    .left_o   (left_out),
    .right_o  (right_out),
    .valid_o  (pair_valid)
  );

  ssr_zero #(.SAMPLE_W(SAMPLE_W), .ZERO_PAIRS(ZERO_PAIRS)) u_zero (
    .clk       (clk),
    .rst       (rst),
    .word_done (word_done),
    .word_chan (word_chan),
    .word_data (word_data),
    .zero_flag (zero_flag)
  );
endmodule

// File: tb/stereo_serial_rx_bench.sv
module stereo_serial_rx_bench;
  localparam int ZP = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rate_dbl = 1'b0;
  logic [5:0]  atten_code = '0;
  logic        bclk_in = 1'b0;
  logic        wsel_in = 1'b0;
  logic        sdata_in = 1'b0;
  logic [15:0] left_out, right_out;
  logic        pair_valid, zero_flag;

  int checks = 0;
  int errors = 0;
  int half   = 6;
  bit done   = 0;
  logic prev_v = 1'b0;

  logic [15:0] exp_l [$];
  logic [15:0] exp_r [$];
  string       exp_tag [$];

  always #10 clk = ~clk;

  stereo_serial_rx #(.ZERO_PAIRS(ZP)) u_stereo_serial_rx (
    .clk(clk), .rst(rst), .rate_dbl(rate_dbl), .atten_code(atten_code),
    .bclk_in(bclk_in), .wsel_in(wsel_in), .sdata_in(sdata_in),
    .left_out(left_out), .right_out(right_out),
    .pair_valid(pair_valid), .zero_flag(zero_flag)
  );

  function automatic logic [15:0] gain_ref(input logic [15:0] s, input int code);
    int v, p, q;
    v = int'($signed(s));
    if (code == 0)  return s;
    if (code == 63) return 16'h0000;
    p = v * (63 - code);
    if (p >= 0) q = p / 64;
    else        q = -((-p + 63) / 64);
    return q[15:0];
  endfunction

  task automatic check1(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic send_word(input logic ws, input logic [15:0] v, input int nbits, input bit glitch);
    for (int i = 0; i < nbits; i++) begin
      wsel_in  = ws;
      sdata_in = (i < 16) ? v[15-i] : i[0];
      bclk_in  = 1'b0;
      repeat (half) @(negedge clk);
      bclk_in = 1'b1;
      if (glitch) begin
        @(negedge clk); bclk_in = 1'b0;
        @(negedge clk); bclk_in = 1'b1;
        repeat (half - 2) @(negedge clk);
      end else begin
        repeat (half) @(negedge clk);
      end
    end
  endtask

  task automatic push_exp(input logic [15:0] l, input logic [15:0] r, input string tag);
    exp_l.push_back(gain_ref(l, int'(atten_code)));
    exp_r.push_back(gain_ref(r, int'(atten_code)));
    exp_tag.push_back(tag);
  endtask

  task automatic send_pair(input logic [15:0] l, input logic [15:0] r, input string tag);
    push_exp(l, r, tag);
    send_word(1'b1, l, 16, 1'b0);
    send_word(1'b0, r, 16, 1'b0);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && pair_valid) begin
      checks++;
      if (prev_v) begin
        errors++;
        $display("FAIL R3: actual valid high two cycles, expected one");
      end
      if (exp_l.size() == 0) begin
        errors++;
        $display("FAIL R3: actual unexpected pair %h/%h, expected none", left_out, right_out);
      end else begin
        string t;
        logic [15:0] el, er;
        el = exp_l.pop_front();
        er = exp_r.pop_front();
        t  = exp_tag.pop_front();
        if (left_out !== el || right_out !== er) begin
          errors++;
          $display("FAIL %s: actual %h/%h expected %h/%h", t, left_out, right_out, el, er);
        end
      end
    end
    prev_v <= pair_valid;
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    // R11 reset state
    check1("R11 left", left_out, 16'h0);
    check1("R11 right", right_out, 16'h0);
    check1("R11 valid", {15'h0, pair_valid}, 16'h0);
    check1("R11 zero", {15'h0, zero_flag}, 16'h0);
    rst = 1'b0;
    repeat (4) @(negedge clk);

    // R1 R2 R4: unity gain, distinct channels
    atten_code = 6'd0;
    send_pair(16'h1234, 16'hA5C3, "R1");
    send_pair(16'h7FFF, 16'h8000, "R4");
    send_pair(16'h0001, 16'hFFFE, "R2");

    // R5 intermediate codes
    atten_code = 6'd1;  send_pair(16'h4000, 16'hC000, "R5 code1");
    atten_code = 6'd31; send_pair(16'h7FFF, 16'h8001, "R5 code31");
    atten_code = 6'd32; send_pair(16'h0123, 16'hFF37, "R5 code32");
    atten_code = 6'd62; send_pair(16'h8000, 16'h0041, "R5 code62");

    // R6 mute
    atten_code = 6'd63; send_pair(16'h7FFF, 16'h8000, "R6");

    // R7 extra bits in a word are ignored
    atten_code = 6'd0;
    push_exp(16'hC3A5, 16'h5A0F, "R7");
    send_word(1'b1, 16'hC3A5, 19, 1'b0);
    send_word(1'b0, 16'h5A0F, 18, 1'b0);

    // R10 glitches in normal rate
    push_exp(16'h2468, 16'hDB97, "R10 normal");
    send_word(1'b1, 16'h2468, 16, 1'b1);
    send_word(1'b0, 16'hDB97, 16, 1'b1);

    // R12 double rate
    rate_dbl = 1'b1; half = 3;
    repeat (4) @(negedge clk);
    send_pair(16'h6B1D, 16'h94E2, "R12");
    atten_code = 6'd20;
    send_pair(16'h8001, 16'h7FFE, "R12 atten");
    push_exp(16'h0F0F, 16'hF0F0, "R10 double");
    send_word(1'b1, 16'h0F0F, 16, 1'b1);
    send_word(1'b0, 16'hF0F0, 16, 1'b1);

    // R8 / R9 zero detection, normal rate
    rate_dbl = 1'b0; half = 6; atten_code = 6'd0;
    repeat (4) @(negedge clk);
    for (int k = 0; k < ZP - 1; k++) send_pair(16'h0, 16'h0, "R8 zero");
    check1("R8 below count", {15'h0, zero_flag}, 16'h0);
    send_pair(16'h0, 16'h0, "R8 zero");
    check1("R8 at count", {15'h0, zero_flag}, 16'h1);
    send_pair(16'h0, 16'h0, "R8 zero");
    check1("R8 stays high", {15'h0, zero_flag}, 16'h1);
    push_exp(16'h0010, 16'h0000, "R9");
    send_word(1'b1, 16'h0010, 16, 1'b0);
    check1("R9 cleared by left", {15'h0, zero_flag}, 16'h0);
    send_word(1'b0, 16'h0000, 16, 1'b0);
    check1("R9 stays clear", {15'h0, zero_flag}, 16'h0);

    repeat (20) @(negedge clk);
    check1("R3 all pairs delivered", 16'(exp_l.size()), 16'h0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule